// File: doc/BRIEF.md
# Serial Audio Pin Role Multiplexer

This block controls two shared pins of a serial audio port: the receive frame-sync pin and the receive bit-clock pin. A set of configuration bits decides each pin's role, and the block then drives the pad's output enable and output value and routes the pad input to its user. The possible roles are general-purpose I/O, a receive clock or frame sync (in or out) in asynchronous mode, a serial flag (in or out) in synchronous mode, and, on the frame-sync pin only, the transmitter's external buffer enable.

Flag traffic moves only on framing boundaries. An output flag shows the value of its control bit as it stood at the last update strobe. An input flag records the pin level at each update strobe, after a two-flop synchronizer. In normal mode the update strobe is the serial core's frame-sync strobe. In network mode it is the core's slot strobe. When a role changes, the pin's driver is released for one cycle before the new role takes over.

Top module: `sai_pin_mux`

## Requirements
- R1: While reset is held and on the first cycle after it, `pad_oe`, `pad_out`, `core_rcv`, `gpio_din` and `if_bits` are all 0.
- R2: Index 0 is the bit-clock pin (flag 0) and index 1 is the frame-sync pin (flag 1). With `cfg_serial_en[i]`=1 and `cfg_sync`=0, pin i is a serial pin. If `cfg_dir[i]`=1 it is an output: `pad_oe[i]`=1 and `pad_out[i]`=`core_drv[i]`. If `cfg_dir[i]`=0 it is an input: `pad_oe[i]`=0 and `core_rcv[i]` follows `pad_in[i]` in the same cycle.
- R3: With `cfg_serial_en[i]`=1 and `cfg_sync`=1, the bit-clock pin is always flag 0. The frame-sync pin is flag 1 when `cfg_xbuf_sel`=0. `cfg_dir[i]`=1 makes the flag an output and 0 makes it an input. In both flag directions `core_rcv[i]` is 0.
- R4: With `cfg_sync`=1 and `cfg_xbuf_sel`=1, the frame-sync pin drives `core_bufen` when `cfg_dir[1]`=1. When `cfg_dir[1]`=0 the pin is disconnected: its output enable is 0, `core_rcv[1]`=0, and `if_bits[1]` holds its value.
- R5: An output-flag pin drives the `of_bits[i]` value sampled at the last update strobe and keeps it between strobes. The update strobe is `core_fs_strobe` when `cfg_net`=0 and `core_slot_strobe` when `cfg_net`=1. The other strobe has no effect.
- R6: For an input-flag pin, `if_bits[i]` takes the pin level through a two-flop synchronizer on each update strobe (same strobe selection as R5). A level applied only one clock before the strobe is not yet captured.
- R7: With `cfg_serial_en[i]`=0, `gpio_mode[2i+1:2i]` selects the pin's GPIO state: 2'b01 is input, 2'b10 is output driving `gpio_dout[i]`, and 2'b00 or 2'b11 is disconnected. `gpio_din[i]` carries the synchronized pin level in input mode and is 0 otherwise.
- R8: A role change on a pin that is not disconnected passes through one cycle of the disconnected state. After a configuration change, the next clock edge leaves the pin undriven, and the edge after that applies the new role. From the disconnected state the new role applies after one edge.
- R9: `core_rcv[i]` is 1 only when pin i is a serial input, so it is never 1 while `pad_oe[i]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_serial_en | input | 2 | Per pin: 1 = serial function, 0 = GPIO |
| cfg_sync | input | 1 | 1 = synchronous mode (flag roles) |
| cfg_xbuf_sel | input | 1 | Frame-sync pin used as transmitter buffer enable in synchronous mode |
| cfg_net | input | 1 | 1 = network mode (slot strobe updates flags) |
| cfg_dir | input | 2 | Per pin direction, 1 = output |
| gpio_mode | input | 4 | Two bits per pin: GPIO state |
| gpio_dout | input | 2 | GPIO output values |
| gpio_din | output | 2 | Synchronized GPIO input values |
| of_bits | input | 2 | Output flag control bits |
| if_bits | output | 2 | Captured input flag bits |
| core_fs_strobe | input | 1 | Frame boundary pulse from the serial core |
| core_slot_strobe | input | 1 | Slot boundary pulse from the serial core |
| core_drv | input | 2 | Serial clock / frame-sync values to drive out |
| core_bufen | input | 1 | Transmitter external buffer enable value |
| core_rcv | output | 2 | Serial clock / frame-sync values received from the pins |
| pad_in | input | 2 | Pad input levels |
| pad_out | output | 2 | Pad output values |
| pad_oe | output | 2 | Pad output enables |

## Verification
The bench examines the frame-sync pin with the buffer-enable select set and the direction bit cleared. A design that decoded only the select bit would drive the pin there when it should be disconnected. Strobe selection is checked by pulsing the strobe that should be ignored in each mode. A wrong multiplexer would then move the output flag or capture the input flag on the wrong boundary. A level applied a single clock before a strobe must not be captured, which exposes a missing synchronizer stage. Role changes are sampled on the edge right after the configuration changes: a design that switched roles directly would show the new driver one cycle early.

// File: rtl/sai_pin_pkg.sv
// Package: shared pin-role encoding and helpers for the serial audio pin mux.
// Assumes two pins per instance: index 0 bit clock, index 1 frame sync.
package sai_pin_pkg;

    typedef enum logic [2:0] {
        ROLE_OFF      = 3'd0,
        ROLE_GPIO_IN  = 3'd1,
        ROLE_GPIO_OUT = 3'd2,
        ROLE_SER_IN   = 3'd3,
        ROLE_SER_OUT  = 3'd4,
        ROLE_FLAG_IN  = 3'd5,
        ROLE_FLAG_OUT = 3'd6,
        ROLE_BUFEN    = 3'd7
    } pin_role_t;

    // True for every role that enables the pad driver.
    function automatic logic role_drives(pin_role_t r);
        return (r == ROLE_GPIO_OUT) || (r == ROLE_SER_OUT) ||
               (r == ROLE_FLAG_OUT) || (r == ROLE_BUFEN);
    endfunction

endpackage

// File: rtl/sai_pin_sync.sv
// Module: multi-stage synchronizer for one asynchronous pad input.
// Assumes STAGES >= 2; output is the last stage, cleared by reset.
module sai_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    // Shift the pad level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sai_pin_role.sv
// Module: decodes one pin's role from configuration and sequences role
// changes through one disconnected cycle. IS_FS selects the frame-sync
// pin variant (buffer-enable role available). Reset leaves the pin off.
module sai_pin_role
    import sai_pin_pkg::*;
#(
    parameter bit IS_FS = 1'b0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      serial_en,
    input  logic      sync_mode,
    input  logic      xbuf_sel,
    input  logic      dir_out,
    input  logic [1:0] gmode,
    output pin_role_t role_q
);
    pin_role_t role_tgt;

    // Pick the requested role from the configuration bits.
    always_comb begin
        role_tgt = ROLE_OFF;
        if (!serial_en) begin
            case (gmode)
                2'b01:   role_tgt = ROLE_GPIO_IN;
                2'b10:   role_tgt = ROLE_GPIO_OUT;
                default: role_tgt = ROLE_OFF;
            endcase
        end else if (!sync_mode) begin
            role_tgt = dir_out ? ROLE_SER_OUT : ROLE_SER_IN;
        end else if (IS_FS && xbuf_sel) begin
            role_tgt = dir_out ? ROLE_BUFEN : ROLE_OFF;
        end else begin
            role_tgt = dir_out ? ROLE_FLAG_OUT : ROLE_FLAG_IN;
        end
    end

    // Move to the requested role, passing through OFF for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                                        role_q <= ROLE_OFF;
        else if (role_tgt != role_q && role_q != ROLE_OFF) role_q <= ROLE_OFF;
        else                                               role_q <= role_tgt;
    end

    // R8
    role_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (role_q != $past(role_q)) |-> ($past(role_q) == ROLE_OFF || role_q == ROLE_OFF));
endmodule

// File: rtl/sai_flag_latch.sv
// Module: output-flag hold register and input-flag capture register for
// one pin. Both move only on the update strobe; capture is further gated
// by the input-flag role. The input is already synchronized.
module sai_flag_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic upd,
    input  logic cap_en,
    input  logic of_bit,
    input  logic pin_sync,
    output logic of_q,
    output logic if_q
);
    // Load the output flag value at each update strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)   of_q <= 1'b0;
        else if (upd) of_q <= of_bit;
    end

    // Capture the synchronized pin level when acting as input flag.
    always_ff @(posedge clk) begin
        if (!rst_n)             if_q <= 1'b0;
        else if (upd && cap_en) if_q <= pin_sync;
    end

    // R5
    of_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(of_q));

    // R6
    if_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd && cap_en) |=> $stable(if_q));

    // R6
    if_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && cap_en) |=> (if_q == $past(pin_sync)));
endmodule

// File: rtl/sai_pin_mux.sv
// Module: top of the serial audio pin multiplexer. Per pin: role decode,
// synchronizer, flag registers and pad steering. Index 0 = bit-clock pin
// (flag 0), index 1 = frame-sync pin (flag 1). Pads are driven when
// pad_oe is set; pad_out is 0 whenever the pin is not driving.
module sai_pin_mux
    import sai_pin_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_serial_en,
    input  logic       cfg_sync,
    input  logic       cfg_xbuf_sel,
    input  logic       cfg_net,
    input  logic [1:0] cfg_dir,
    input  logic [3:0] gpio_mode,
    input  logic [1:0] gpio_dout,
    output logic [1:0] gpio_din,
    input  logic [1:0] of_bits,
    output logic [1:0] if_bits,
    input  logic       core_fs_strobe,
    input  logic       core_slot_strobe,
    input  logic [1:0] core_drv,
    input  logic       core_bufen,
    output logic [1:0] core_rcv,
    input  logic [1:0] pad_in,
    output logic [1:0] pad_out,
    output logic [1:0] pad_oe
);
    localparam int NPINS = 2;

    logic upd;

    // Choose the flag update strobe for the current framing mode.
    assign upd = cfg_net ? core_slot_strobe : core_fs_strobe;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pin_role_t role;
        logic      pin_s;
        logic      of_q;

        sai_pin_role #(.IS_FS(i == 1)) u_role (
            .clk       (clk),
            .rst_n     (rst_n),
            .serial_en (cfg_serial_en[i]),
            .sync_mode (cfg_sync),
            .xbuf_sel  (cfg_xbuf_sel),
            .dir_out   (cfg_dir[i]),
            .gmode     (gpio_mode[2*i +: 2]),
            .role_q    (role)
        );

        sai_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (pad_in[i]),
            .q     (pin_s)
        );

        sai_flag_latch u_flag (
            .clk      (clk),
            .rst_n    (rst_n),
            .upd      (upd),
            .cap_en   (role == ROLE_FLAG_IN),
            .of_bit   (of_bits[i]),
            .pin_sync (pin_s),
            .of_q     (of_q),
            .if_q     (if_bits[i])
        );

        // Steer the pad output value from the active role's source.
        always_comb begin
            case (role)
                ROLE_GPIO_OUT: pad_out[i] = gpio_dout[i];
                ROLE_SER_OUT:  pad_out[i] = core_drv[i];
                ROLE_FLAG_OUT: pad_out[i] = of_q;
                ROLE_BUFEN:    pad_out[i] = core_bufen;
                default:       pad_out[i] = 1'b0;
            endcase
        end

        // Enable the driver and route inputs according to the role.
        assign pad_oe[i]   = role_drives(role);
        assign core_rcv[i] = (role == ROLE_SER_IN)  ? pad_in[i] : 1'b0;
        assign gpio_din[i] = (role == ROLE_GPIO_IN) ? pin_s     : 1'b0;

        // R9
        rcv_vs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
            core_rcv[i] |-> !pad_oe[i]);
    end
endmodule

// File: tb/sai_pin_mux_tb.sv
module sai_pin_mux_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cfg_serial_en = '0;
    logic cfg_sync = 1'b0, cfg_xbuf_sel = 1'b0, cfg_net = 1'b0;
    logic [1:0] cfg_dir = '0;
    logic [3:0] gpio_mode = '0;
    logic [1:0] gpio_dout = '0, of_bits = '0, core_drv = '0, pad_in = '0;
    logic core_fs_strobe = 1'b0, core_slot_strobe = 1'b0, core_bufen = 1'b0;
    logic [1:0] gpio_din, if_bits, core_rcv, pad_out, pad_oe;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sai_pin_mux u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_serial_en(cfg_serial_en), .cfg_sync(cfg_sync),
        .cfg_xbuf_sel(cfg_xbuf_sel), .cfg_net(cfg_net), .cfg_dir(cfg_dir),
        .gpio_mode(gpio_mode), .gpio_dout(gpio_dout), .gpio_din(gpio_din),
        .of_bits(of_bits), .if_bits(if_bits), .core_fs_strobe(core_fs_strobe),
        .core_slot_strobe(core_slot_strobe), .core_drv(core_drv), .core_bufen(core_bufen),
        .core_rcv(core_rcv), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // Stimulus [22:6]: sen2 sync xbuf dir2 gmode4 pad_in2 drv2 bufen gdout2
    // Expected [5:0]: pad_oe2 pad_out2 core_rcv2
    localparam int NV = 11;
    localparam logic [22:0] VEC [NV] = '{
        {2'b11,1'b0,1'b0,2'b11,4'b0000,2'b00,2'b10,1'b0,2'b00, 2'b11,2'b10,2'b00}, // R2 both out
        {2'b11,1'b0,1'b0,2'b00,4'b0000,2'b01,2'b11,1'b0,2'b00, 2'b00,2'b00,2'b01}, // R2 both in
        {2'b11,1'b0,1'b0,2'b10,4'b0000,2'b11,2'b01,1'b0,2'b00, 2'b10,2'b00,2'b01}, // R2 mixed
        {2'b11,1'b1,1'b0,2'b11,4'b0000,2'b00,2'b11,1'b0,2'b00, 2'b11,2'b00,2'b00}, // R3 flags out
        {2'b11,1'b1,1'b0,2'b00,4'b0000,2'b11,2'b11,1'b0,2'b00, 2'b00,2'b00,2'b00}, // R3 flags in
        {2'b11,1'b1,1'b1,2'b10,4'b0000,2'b00,2'b00,1'b1,2'b00, 2'b10,2'b10,2'b00}, // R4 bufen
        {2'b11,1'b1,1'b1,2'b01,4'b0000,2'b11,2'b11,1'b1,2'b00, 2'b01,2'b00,2'b00}, // R4 fs off
        {2'b00,1'b0,1'b0,2'b00,4'b1001,2'b11,2'b00,1'b0,2'b11, 2'b10,2'b10,2'b00}, // R7 out/in
        {2'b00,1'b0,1'b0,2'b11,4'b0000,2'b11,2'b11,1'b1,2'b11, 2'b00,2'b00,2'b00}, // R7 off 00
        {2'b00,1'b0,1'b0,2'b11,4'b1111,2'b11,2'b11,1'b1,2'b11, 2'b00,2'b00,2'b00}, // R7 off 11
        {2'b01,1'b0,1'b0,2'b01,4'b1000,2'b00,2'b01,1'b0,2'b10, 2'b11,2'b11,2'b00}  // R2 R7 mixed
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string tag, logic [5:0] act, logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic pulse(bit slot);
        if (slot) core_slot_strobe = 1'b1; else core_fs_strobe = 1'b1;
        step();
        core_slot_strobe = 1'b0;
        core_fs_strobe = 1'b0;
    endtask

    task automatic set_cfg(logic [16:0] s);
        {cfg_serial_en, cfg_sync, cfg_xbuf_sel, cfg_dir, gpio_mode,
         pad_in, core_drv, core_bufen, gpio_dout} = s;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cfg_serial_en = 2'b11; cfg_dir = 2'b11; pad_in = 2'b11; gpio_mode = 4'b0101;
        @(negedge clk); step(); step();
        // R1 reset state
        chk("R1 oe/out/rcv", {pad_oe, pad_out, core_rcv}, 6'b0);
        chk("R1 din/if", {2'b00, gpio_din, if_bits}, 6'b0);
        rst_n = 1'b1;
        cfg_serial_en = '0; cfg_dir = '0; pad_in = '0; gpio_mode = '0;
        step();
        chk("R1 after release", {pad_oe, pad_out, core_rcv}, 6'b0);

        for (int v = 0; v < NV; v++) begin
            set_cfg(VEC[v][22:6]);
            step(); step(); step();
            chk($sformatf("R2/R3/R4/R7 vec %0d", v), {pad_oe, pad_out, core_rcv}, VEC[v][5:0]);
        end

        // R8: async both out -> GPIO both out passes through off for one cycle
        set_cfg({2'b11,1'b0,1'b0,2'b11,4'b0000,2'b00,2'b11,1'b0,2'b00});
        step(); step(); step();
        set_cfg({2'b00,1'b0,1'b0,2'b11,4'b1010,2'b00,2'b11,1'b0,2'b11});
        step();
        chk("R8 gap cycle", {pad_oe, pad_out, 2'b00}, 6'b000000);
        step();
        chk("R8 new role", {pad_oe, pad_out, 2'b00}, 6'b111100);
        // R8: from off the new role applies after one edge
        gpio_mode = 4'b0000; step(); step();
        gpio_mode = 4'b1010; step();
        chk("R8 from off", {pad_oe, pad_out, 2'b00}, 6'b111100);

        // R5 output flags, normal mode
        set_cfg({2'b11,1'b1,1'b0,2'b11,4'b0000,2'b00,2'b00,1'b0,2'b00});
        cfg_net = 1'b0; step(); step(); step();
        of_bits = 2'b11; step();
        chk("R5 hold before strobe", {pad_oe, pad_out, 2'b00}, 6'b110000);
        pulse(1'b1);
        chk("R5 slot ignored normal", {pad_oe, pad_out, 2'b00}, 6'b110000);
        pulse(1'b0);
        chk("R5 fs strobe load", {pad_oe, pad_out, 2'b00}, 6'b111100);
        // R5 network mode
        cfg_net = 1'b1; of_bits = 2'b01;
        pulse(1'b0);
        chk("R5 fs ignored network", {pad_oe, pad_out, 2'b00}, 6'b111100);
        pulse(1'b1);
        chk("R5 slot strobe load", {pad_oe, pad_out, 2'b00}, 6'b110100);

        // R6 input flags
        cfg_net = 1'b0; cfg_dir = 2'b00; pad_in = 2'b10;
        step(); step(); step();
        pulse(1'b0);
        chk("R6 capture", {4'b0, if_bits}, 6'b000010);
        pad_in = 2'b01;
        pulse(1'b0);
        chk("R6 sync latency", {4'b0, if_bits}, 6'b000010);
        step(); step();
        pulse(1'b1);
        chk("R6 slot ignored normal", {4'b0, if_bits}, 6'b000010);
        pulse(1'b0);
        chk("R6 capture new", {4'b0, if_bits}, 6'b000001);

        // R4 disconnected frame-sync pin keeps its flag
        cfg_xbuf_sel = 1'b1; cfg_dir = 2'b00; pad_in = 2'b10;
        step(); step(); step();
        pulse(1'b0);
        chk("R4 fs off if held", {pad_oe, 2'b00, if_bits}, 6'b000000);

        // R7 GPIO input synchronized
        set_cfg({2'b00,1'b0,1'b0,2'b00,4'b0101,2'b11,2'b00,1'b0,2'b00});
        step(); step(); step();
        chk("R7 gpio in", {pad_oe, core_rcv, gpio_din}, 6'b000011);
        gpio_mode = 4'b0000; step(); step();
        chk("R7 gpio off ignores pin", {pad_oe, core_rcv, gpio_din}, 6'b000000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule